// File: doc/BRIEF.md
# Overcurrent Pulse-Skip and Latch-Off Supervisor

This block supervises a synchronous buck converter from the digital side. Comparator results arrive as flags: a current-limit flag, an undervoltage flag and a flag that says the output voltage setpoint is being changed. The block also receives an enable level and a slow square wave taken from the switching oscillator. Every input is brought into the system clock domain through a two-flop stage. A single-cycle tick is formed on each rising edge of the switching wave, and all window counting advances on that tick.

While the current limit is active, the high-side drive is held off, so switching pulses are skipped. The first tick that sees the flag starts a window of sixteen switching cycles. In the first eight cycles the flag may come and go freely. Any flag seen in the last eight cycles is treated as a sustained overload, and the converter latches off. When the window runs out with no flag in its second half, the detector rearms on its own. An undervoltage flag latches the converter off at once, unless a setpoint change is in progress. A latched fault holds the converter off and kills power-good until enable is dropped or reset is applied.

Top module: `ocp_supervisor`

## Requirements
- R1: Every input passes through two system-clock flops. A change on `ilim_flag` reaches `hs_inhibit` on the second rising clock edge after it is applied, provided the converter is running.
- R2: `hs_inhibit` is high whenever the synchronized current-limit flag is high or the converter is not running.
- R3: One switching cycle is marked by each rising edge of the synchronized `sw_clk`. The window counts only these cycles, not system clocks.
- R4: The switching cycle in which the current-limit flag is first seen starts a grace period of 8 switching cycles, including that first one. A flag seen during the grace period does not latch a fault.
- R5: The flag seen in any of the 8 switching cycles that follow the grace period sets `fault_latched` on the next system clock edge.
- R6: Sixteen switching cycles after the first trip, with no flag in the second half, the detector returns to idle. A later flag is then treated as a new first trip and gets its own grace period.
- R7: While `fault_latched` is 1, `conv_enable` is 0, `pg_kill` is 1 and `hs_inhibit` is 1. The fault holds as long as enable stays high.
- R8: A synchronized low on `en_in` clears the fault and the window. It also forces `conv_enable` to 0 and `pg_kill` to 1.
- R9: With enable high and `vchg_busy` low, a synchronized high on `uv_flag` sets `fault_latched` on the next system clock edge. It does not wait for any switching cycle.
- R10: While the synchronized `vchg_busy` is high, `uv_flag` has no effect on the fault.
- R11: While `rst_n` is low, `fault_latched` is 0, `conv_enable` is 0, `pg_kill` is 1 and `hs_inhibit` is 1. Reset is released into the system clock through two flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sw_clk | input | 1 | Square wave from the switching oscillator |
| ilim_flag | input | 1 | Current-limit comparator result |
| uv_flag | input | 1 | Undervoltage comparator result |
| vchg_busy | input | 1 | High while a voltage-setpoint change is in progress |
| en_in | input | 1 | Converter enable level |
| hs_inhibit | output | 1 | Holds the high-side drive off |
| fault_latched | output | 1 | Latched overload or undervoltage fault |
| pg_kill | output | 1 | Forces power-good low |
| conv_enable | output | 1 | Converter allowed to switch |

## Verification
The overcurrent path is tried with four patterns:
- A short burst that clears inside the grace period. This tells a transient apart from an overload.
- A burst, a quiet gap, then a second burst that lands in the second half of the window. This shows that the latch depends on the cycle position and not on the flag's duration.
- Two bursts spaced beyond sixteen cycles. This shows the rearm.
- A flag held continuously. This latches as soon as the grace period ends.

Undervoltage is applied with the setpoint-change flag both high and low, which separates the ignore path from the immediate latch. Enable toggles and a mid-run reset show which state each clear path removes.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic {
    WIN_IDLE  = 1'b0,
    WIN_ARMED = 1'b1
  } win_state_e;
endpackage

// File: rtl/ocp_sync2.sv
module ocp_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/ocp_cycle_tick.sv
module ocp_cycle_tick (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_s,
  output logic tick
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sw_s;
  end

  assign tick = sw_s & ~prev_q;

  // R3: a tick is one system cycle wide
  p_tick_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/ocp_window.sv
module ocp_window
  import ocp_pkg::*;
#(
  parameter int GRACE_CYC = 8,
  parameter int WATCH_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic flag,
  input  logic clear,
  output logic trip
);
  localparam int TOTAL_CYC = GRACE_CYC + WATCH_CYC;
  localparam int CW        = $clog2(TOTAL_CYC + 1);
  localparam logic [CW-1:0] LAST_C  = CW'(TOTAL_CYC - 1);
  localparam logic [CW-1:0] GRACE_C = CW'(GRACE_CYC);

  win_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          in_watch;

  assign in_watch = (state_q == WIN_ARMED) && (cnt_q >= GRACE_C);
  assign trip     = tick && flag && in_watch && !clear;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (clear) begin
      state_d = WIN_IDLE;
      cnt_d   = '0;
    end else if (tick) begin
      unique case (state_q)
        WIN_IDLE: begin
          if (flag) begin
            state_d = WIN_ARMED;
            cnt_d   = CW'(1);
          end
        end
        WIN_ARMED: begin
          if (cnt_q == LAST_C) begin
            state_d = WIN_IDLE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        default: begin
          state_d = WIN_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WIN_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // R6: the count never passes the window length
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_C);
  // R3: the count moves only on a switching tick or a clear
  p_cnt_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clear) |=> $stable(cnt_q));
  // R4: a trip never comes from the grace period
  p_no_grace_trip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WIN_ARMED && cnt_q < GRACE_C) |-> !trip);
endmodule

// File: rtl/ocp_supervisor.sv
module ocp_supervisor #(
  parameter int GRACE_CYC = 8,
  parameter int WATCH_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_clk,
  input  logic ilim_flag,
  input  logic uv_flag,
  input  logic vchg_busy,
  input  logic en_in,
  output logic hs_inhibit,
  output logic fault_latched,
  output logic pg_kill,
  output logic conv_enable
);
  localparam int NIN = 5;

  logic           rst_r1_q, rst_r2_q, rst_i;
  logic [NIN-1:0] raw_in, syn_in;
  logic           sw_s, ilim_s, uv_s, vchg_s, en_s;
  logic           tick, ocp_trip, uv_trip, win_clear;
  logic           fault_q, fault_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_r1_q <= 1'b0;
      rst_r2_q <= 1'b0;
    end else begin
      rst_r1_q <= 1'b1;
      rst_r2_q <= rst_r1_q;
    end
  end
  assign rst_i = rst_r2_q;

  assign raw_in = {sw_clk, ilim_flag, uv_flag, vchg_busy, en_in};

  ocp_sync2 #(.W(NIN)) u_sync (
    .clk   (clk),
    .rst_n (rst_i),
    .d     (raw_in),
    .q     (syn_in)
  );
  assign {sw_s, ilim_s, uv_s, vchg_s, en_s} = syn_in;

  ocp_cycle_tick u_tick (
    .clk   (clk),
    .rst_n (rst_i),
    .sw_s  (sw_s),
    .tick  (tick)
  );

  assign win_clear = !en_s || fault_q;

  ocp_window #(.GRACE_CYC(GRACE_CYC), .WATCH_CYC(WATCH_CYC)) u_win (
    .clk   (clk),
    .rst_n (rst_i),
    .tick  (tick),
    .flag  (ilim_s),
    .clear (win_clear),
    .trip  (ocp_trip)
  );

  assign uv_trip = uv_s && !vchg_s;

  always_comb begin
    fault_d = fault_q;
    if (!en_s)                   fault_d = 1'b0;
    else if (ocp_trip || uv_trip) fault_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) fault_q <= 1'b0;
    else        fault_q <= fault_d;
  end

  assign conv_enable   = en_s && !fault_q;
  assign pg_kill       = !conv_enable;
  assign hs_inhibit    = ilim_s || !conv_enable;
  assign fault_latched = fault_q;

  // R7: a fault holds while enable stays high
  p_fault_hold_r7: assert property (@(posedge clk) disable iff (!rst_i)
    (fault_q && en_s) |=> fault_q);
  // R8: a low enable clears the fault
  p_en_clear_r8: assert property (@(posedge clk) disable iff (!rst_i)
    !en_s |=> !fault_q);
  // R9: an undervoltage outside a setpoint change latches at once
  p_uv_latch_r9: assert property (@(posedge clk) disable iff (!rst_i)
    (en_s && uv_s && !vchg_s) |=> fault_q);
  // R10: a new fault during a setpoint change comes only from the window
  p_uv_masked_r10: assert property (@(posedge clk) disable iff (!rst_i)
    (!fault_q && vchg_s && !ocp_trip) |=> !fault_q);
  // R2: the current limit always skips the high-side pulse
  p_inhibit_r2: assert property (@(posedge clk) disable iff (!rst_i)
    ilim_s |-> hs_inhibit);
endmodule

// File: tb/sim_ocp_supervisor.sv
module sim_ocp_supervisor;
  localparam int GRACE = 8;
  localparam int TOTAL = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_clk = 1'b0, ilim = 1'b0, uv = 1'b0, vchg = 1'b0, en = 1'b0;
  logic hs_inhibit, fault_latched, pg_kill, conv_enable;

  int n_chk = 0;
  int n_fail = 0;
  bit sw_run = 1'b0;

  always #4 clk = ~clk;

  ocp_supervisor u0 (
    .clk(clk), .rst_n(rst_n), .sw_clk(sw_clk), .ilim_flag(ilim),
    .uv_flag(uv), .vchg_busy(vchg), .en_in(en),
    .hs_inhibit(hs_inhibit), .fault_latched(fault_latched),
    .pg_kill(pg_kill), .conv_enable(conv_enable)
  );

  // behavioural reference: delay lines kept as queues
  bit q_rst[$];
  bit h_sw[$], h_il[$], h_uv[$], h_vc[$], h_en[$];
  bit sw_prev;
  bit m_fault;
  int m_k;   // -1 idle, otherwise switching cycles since first trip

  function automatic bit last(ref bit q[$]);
    return q[q.size()-1];
  endfunction

  task automatic model_clear();
    q_rst = '{0, 0};
    h_sw = '{0, 0}; h_il = '{0, 0}; h_uv = '{0, 0};
    h_vc = '{0, 0}; h_en = '{0, 0};
    sw_prev = 1'b0; m_fault = 1'b0; m_k = -1;
  endtask

  initial model_clear();

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      model_clear();
    end else if (!last(q_rst)) begin
      q_rst.push_front(1'b1); void'(q_rst.pop_back());
    end else begin
      bit s_en, s_il, s_uv, s_vc, s_sw, tk, trip;
      s_en = last(h_en); s_il = last(h_il); s_uv = last(h_uv);
      s_vc = last(h_vc); s_sw = last(h_sw);
      tk   = s_sw && !sw_prev;
      trip = tk && s_il && m_k >= GRACE && en;
      if (!s_en || m_fault) m_k = -1;
      else if (tk) begin
        if (m_k < 0) begin if (s_il) m_k = 1; end
        else if (m_k == TOTAL - 1) m_k = -1;
        else m_k = m_k + 1;
      end
      if (!s_en) m_fault = 1'b0;
      else if (trip || (s_uv && !s_vc)) m_fault = 1'b1;
      sw_prev = s_sw;
      h_sw.push_front(sw_clk); void'(h_sw.pop_back());
      h_il.push_front(ilim);   void'(h_il.pop_back());
      h_uv.push_front(uv);     void'(h_uv.pop_back());
      h_vc.push_front(vchg);   void'(h_vc.pop_back());
      h_en.push_front(en);     void'(h_en.pop_back());
    end
  end

  task automatic check(string req, string what, bit act, bit exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare on every clock, half a period after the edge
  always @(negedge clk) begin
    bit m_run;
    m_run = last(h_en) && !m_fault && last(q_rst);
    check("R2", "hs_inhibit", hs_inhibit, last(h_il) || !m_run);
    check("R5", "fault_latched", fault_latched, m_fault);
    check("R7", "conv_enable", conv_enable, m_run);
    check("R7", "pg_kill", pg_kill, !m_run);
  end

  // switching wave: 8 system clocks per cycle
  initial begin
    forever begin
      @(negedge clk);
      if (sw_run) begin
        repeat (3) @(negedge clk);
        sw_clk = ~sw_clk;
      end
    end
  end

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cycle_en();
    en = 1'b0; wait_clk(6); en = 1'b1; wait_clk(6);
  endtask

  initial begin : watchdog
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait_clk(5);
    check("R11", "reset fault", fault_latched, 1'b0);
    check("R11", "reset conv_enable", conv_enable, 1'b0);
    check("R11", "reset pg_kill", pg_kill, 1'b1);
    check("R11", "reset hs_inhibit", hs_inhibit, 1'b1);
    rst_n = 1'b1; en = 1'b1; sw_run = 1'b1;
    wait_clk(20);
    check("R7", "running", conv_enable, 1'b1);

    // R1: inhibit follows the flag after two edges
    ilim = 1'b1;
    @(posedge clk); #1 check("R1", "inhibit after one edge", hs_inhibit, 1'b0);
    @(posedge clk); #1 check("R1", "inhibit after two edges", hs_inhibit, 1'b1);
    @(negedge clk); wait_clk(10); ilim = 1'b0;
    wait_clk(200);
    check("R4", "short burst no latch", fault_latched, 1'b0);

    // R5: second burst in the watch half
    ilim = 1'b1; wait_clk(10); ilim = 1'b0;
    wait_clk(80); ilim = 1'b1; wait_clk(12); ilim = 1'b0;
    wait_clk(4);
    check("R5", "late burst latches", fault_latched, 1'b1);
    wait_clk(100);
    check("R7", "fault held", conv_enable, 1'b0);

    // R8: enable toggle clears
    cycle_en();
    check("R8", "cleared by enable", fault_latched, 1'b0);
    en = 1'b0; wait_clk(4);
    check("R8", "enable low pg_kill", pg_kill, 1'b1);
    en = 1'b1; wait_clk(200);

    // R6: bursts spaced beyond the window
    ilim = 1'b1; wait_clk(10); ilim = 1'b0;
    wait_clk(170);
    ilim = 1'b1; wait_clk(10); ilim = 1'b0;
    wait_clk(200);
    check("R6", "rearmed, no latch", fault_latched, 1'b0);

    // R3: flag held, latches once grace cycles pass
    ilim = 1'b1; wait_clk(40);
    check("R3", "held flag within grace", fault_latched, 1'b0);
    wait_clk(60);
    check("R5", "held flag latches", fault_latched, 1'b1);
    ilim = 1'b0; cycle_en(); wait_clk(50);

    // R10 / R9: undervoltage masked, then immediate
    vchg = 1'b1; uv = 1'b1; wait_clk(30);
    check("R10", "uv during setpoint change", fault_latched, 1'b0);
    vchg = 1'b0; wait_clk(3);
    check("R9", "uv latches", fault_latched, 1'b1);
    uv = 1'b0; cycle_en(); wait_clk(20);
    check("R8", "cleared after uv", conv_enable, 1'b1);

    // R11: reset mid-run
    ilim = 1'b1; wait_clk(10); rst_n = 1'b0; #1;
    check("R11", "mid reset disables", conv_enable, 1'b0);
    ilim = 1'b0; wait_clk(4); rst_n = 1'b1; wait_clk(20);
    check("R11", "resume after reset", conv_enable, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule